// File: doc/BRIEF.md
# NAND Transaction Phase Sequencer

This block carries out a single NAND flash transaction as a fixed series of phases: an optional column-pointer command, a first command byte, a run of address bytes, a data transfer, an optional second command byte and a wait on the device's ready line. A set of enable flags picks which phases run. A direction flag picks whether bytes are pulled from the write FIFO or pushed into the read FIFO. In the write direction the data goes out before the second command (program: 0x80, address, data, 0x10). In the read direction the second command and the ready wait come first, and the data is read after them (page read: 0x00, address, 0x30, data).

A sector mode sets the byte count from a sector count, with each sector made of 512 data bytes and then 16 spare bytes. A flag marks the spare bytes. Software starts a transaction with a one-cycle strobe. It learns of completion from a sticky end flag, which it clears itself. Every strobe toward the flash lasts one cycle. Pin-level NAND timing and ECC are handled outside this block.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `xferEnd` and every pin and FIFO strobe are low.
- R2: In the write direction the order is: pointer command (if enabled), first command, address, data, second command (if enabled), ready wait, then end. Each command or address byte is one cycle of `pinCmdLatch` or `pinAddrLatch`. The first strobe appears in the cycle right after the clock edge that sampled `start`. Address bytes go out least significant byte first, and `addrCycles` of them are sent.
- R3: In the read direction the order is: first command, address, second command (if enabled), ready wait, data, then end.
- R4: A disabled phase is skipped. Address enabled with `addrCycles` = 0 also skips the address phase. An erase (0x60, three address bytes, 0xD0, no data) produces exactly those five strobes.
- R5: Outside sector mode, exactly `byteCount` data bytes move. A count of zero skips the data phase. A status read (address off) moves 1 byte, and an ID read moves 8.
- R6: With `sectorMode` = 1, the block moves `sectorCount` × 528 bytes and ignores `byteCount`. `spareByte` is high on bytes 512..527 of each sector, counted from 0.
- R7: A data byte moves only in a cycle where `fifoWrValid` (write direction) or `fifoRdReady` (read direction) is high. In any other cycle the data phase stalls with no strobe.
- R8: The ready wait holds while `readyIn` is low. In the write direction `xferEnd` rises on the edge that samples `readyIn` high.
- R9: `xferEnd` stays high until `endClear` is pulsed. On the same edge a completion has priority over a clear.
- R10: The pointer command code depends on `ptrColumn`. It is 0x50 if the column is at or above the page size (512), 0x00 if the column is below 256, and 0x01 otherwise.
- R11: `start` has no effect while `busy` is high. The codes, counts and enables captured at launch stay in use for the whole transaction.
- R12: During a read byte, `fifoRdPush` is high and `fifoRdData` carries `pinDataIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, honoured only when idle |
| cmd1Code | input | 8 | First command byte |
| cmd2Code | input | 8 | Second command byte |
| enPtr | input | 1 | Enable the pointer command phase |
| ptrColumn | input | 12 | Column used to select the pointer code |
| enCmd1 | input | 1 | Enable the first command |
| enAddr | input | 1 | Enable the address phase |
| enCmd2 | input | 1 | Enable the second command |
| dirWrite | input | 1 | 1: data from write FIFO; 0: data into read FIFO |
| sectorMode | input | 1 | Byte count taken from sectors of 512+16 bytes |
| addrCycles | input | 3 | Number of address bytes |
| addrBytes | input | 40 | Address bytes, least significant sent first |
| byteCount | input | 16 | Data bytes outside sector mode |
| sectorCount | input | 3 | Sectors in sector mode |
| endClear | input | 1 | Clears the end flag |
| readyIn | input | 1 | Device ready (1) / busy (0) |
| pinCmdLatch | output | 1 | Command byte on `pinDataOut` |
| pinAddrLatch | output | 1 | Address byte on `pinDataOut` |
| pinWrStrobe | output | 1 | Write data byte on `pinDataOut` |
| pinRdStrobe | output | 1 | Read data byte taken from `pinDataIn` |
| pinDataOut | output | 8 | Byte driven toward the device |
| pinDataIn | input | 8 | Byte returned by the device |
| fifoWrValid | input | 1 | Write FIFO holds a byte |
| fifoWrData | input | 8 | Head byte of the write FIFO |
| fifoWrPop | output | 1 | Write FIFO byte consumed |
| fifoRdReady | input | 1 | Read FIFO can accept a byte |
| fifoRdPush | output | 1 | Byte pushed into the read FIFO |
| fifoRdData | output | 8 | Byte pushed into the read FIFO |
| spareByte | output | 1 | Current data byte is a spare byte of its sector |
| busy | output | 1 | Transaction in progress |
| xferEnd | output | 1 | Sticky transaction-end flag |

## Verification
The first command or pointer strobe appears in the cycle after the edge that samples `start`. After that, each phase byte takes exactly one cycle. Data bytes are the exception: they take one cycle each only while the FIFO side is ready. The ready wait takes one cycle when `readyIn` is already high. `xferEnd` is visible in the cycle after the last data byte (read direction) or after the ready sample (write direction). The bench drives every input on the falling edge and samples every output on the following falling edge. It records each strobe together with its byte and compares the recorded list with an expected list built from the requirements, so timing slack from stalls does not upset the order checks. The ready and clear checks sample exactly one falling edge after the input that causes them.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PTR, ST_CMD1, ST_ADDR, ST_DATA, ST_CMD2, ST_WAIT
  } phase_e;

  typedef struct packed {
    logic enPtr;
    logic enCmd1;
    logic enAddr;   // already qualified by a non-zero address count
    logic enCmd2;
    logic dirWrite;
    logic noData;
  } seq_cfg_t;

  typedef struct packed {
    logic load;
    logic selPtr;
    logic selCmd1;
    logic selCmd2;
    logic selAddr;
    logic selData;
    logic wrStep;
    logic rdStep;
  } seq_ctl_t;

  localparam logic [7:0] PTR_SPARE = 8'h50;
  localparam logic [7:0] PTR_LOW   = 8'h00;
  localparam logic [7:0] PTR_HIGH  = 8'h01;

  function automatic phase_e afterWdata(seq_cfg_t c);
    return c.enCmd2 ? ST_CMD2 : ST_WAIT;
  endfunction

  function automatic phase_e afterAddr(seq_cfg_t c);
    if (c.dirWrite && !c.noData) return ST_DATA;
    return afterWdata(c);
  endfunction

  function automatic phase_e afterCmd1(seq_cfg_t c);
    return c.enAddr ? ST_ADDR : afterAddr(c);
  endfunction

  function automatic phase_e afterPtr(seq_cfg_t c);
    return c.enCmd1 ? ST_CMD1 : afterCmd1(c);
  endfunction

  function automatic phase_e entryPhase(seq_cfg_t c);
    return c.enPtr ? ST_PTR : afterPtr(c);
  endfunction

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  seq_cfg_t cfgIn,
  input  logic     readyIn,
  input  logic     fifoWrValid,
  input  logic     fifoRdReady,
  input  logic     addrLast,
  input  logic     dataLast,
  input  logic     endClear,
  output seq_ctl_t ctl,
  output logic     busy,
  output logic     xferEnd
);

  phase_e   state, nextState;
  seq_cfg_t cfgQ;
  logic     finish;
  logic     dataGo;

  assign dataGo = (state == ST_DATA) &&
                  (cfgQ.dirWrite ? fifoWrValid : fifoRdReady);

  always_comb begin
    nextState = state;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: if (start) nextState = entryPhase(cfgIn);
      ST_PTR:  nextState = afterPtr(cfgQ);
      ST_CMD1: nextState = afterCmd1(cfgQ);
      ST_ADDR: if (addrLast) nextState = afterAddr(cfgQ);
      ST_CMD2: nextState = ST_WAIT;
      ST_WAIT: if (readyIn) begin
        if (!cfgQ.dirWrite && !cfgQ.noData) nextState = ST_DATA;
        else begin
          nextState = ST_IDLE;
          finish    = 1'b1;
        end
      end
      ST_DATA: if (dataGo && dataLast) begin
        if (cfgQ.dirWrite) nextState = afterWdata(cfgQ);
        else begin
          nextState = ST_IDLE;
          finish    = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cfgQ    <= '0;
      xferEnd <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) cfgQ <= cfgIn;
      if (finish)        xferEnd <= 1'b1;
      else if (endClear) xferEnd <= 1'b0;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == ST_IDLE) && start;
    ctl.selPtr  = (state == ST_PTR);
    ctl.selCmd1 = (state == ST_CMD1);
    ctl.selCmd2 = (state == ST_CMD2);
    ctl.selAddr = (state == ST_ADDR);
    ctl.selData = (state == ST_DATA);
    ctl.wrStep  = dataGo && cfgQ.dirWrite;
    ctl.rdStep  = dataGo && !cfgQ.dirWrite;
  end

  assign busy = (state != ST_IDLE);

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !readyIn) |=> (state == ST_WAIT)); // R8
  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (xferEnd && !endClear) |=> xferEnd); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(cfgQ)); // R11
  AST_STALL_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && cfgQ.dirWrite && !fifoWrValid) |=> (state == ST_DATA)); // R7

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int ADDR_MAX   = 5,
  parameter int BCNT_W     = 16,
  parameter int SCNT_W     = 3,
  parameter int COL_W      = 12,
  parameter int PAGE_BYTES = 512,
  parameter int SECT_DATA  = 512,
  parameter int SECT_SPARE = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_ctl_t              ctl,
  input  logic [7:0]            cmd1Code,
  input  logic [7:0]            cmd2Code,
  input  logic [COL_W-1:0]      ptrColumn,
  input  logic [8*ADDR_MAX-1:0] addrBytes,
  input  logic [$clog2(ADDR_MAX+1)-1:0] addrCycles,
  input  logic [BCNT_W-1:0]     byteCount,
  input  logic [SCNT_W-1:0]     sectorCount,
  input  logic                  sectorMode,
  input  logic [7:0]            fifoWrData,
  output logic [7:0]            busOut,
  output logic                  addrLast,
  output logic                  dataLast,
  output logic                  spareByte
);

  localparam int ADDR_W     = 8 * ADDR_MAX;
  localparam int ACNT_W     = $clog2(ADDR_MAX + 1);
  localparam int SECT_TOTAL = SECT_DATA + SECT_SPARE;
  localparam int IDX_W      = $clog2(SECT_TOTAL);

  logic [7:0]        cmd1Q, cmd2Q, ptrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [ACNT_W-1:0] addrLeft;
  logic [BCNT_W-1:0] dataLeft;
  logic [IDX_W-1:0]  secIdx;
  logic              sectorModeQ;
  logic [BCNT_W-1:0] sectorTotal;
  logic [7:0]        ptrCode;
  logic              dataStep;

  assign sectorTotal = BCNT_W'(sectorCount) * BCNT_W'(SECT_TOTAL);
  assign dataStep    = ctl.wrStep | ctl.rdStep;

  always_comb begin
    if (ptrColumn >= COL_W'(PAGE_BYTES))       ptrCode = PTR_SPARE;
    else if (ptrColumn < COL_W'(PAGE_BYTES/2)) ptrCode = PTR_LOW;
    else                                       ptrCode = PTR_HIGH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd1Q       <= '0;
      cmd2Q       <= '0;
      ptrQ        <= '0;
      addrQ       <= '0;
      addrLeft    <= '0;
      dataLeft    <= '0;
      secIdx      <= '0;
      sectorModeQ <= 1'b0;
    end else if (ctl.load) begin
      cmd1Q       <= cmd1Code;
      cmd2Q       <= cmd2Code;
      ptrQ        <= ptrCode;
      addrQ       <= addrBytes;
      addrLeft    <= addrCycles;
      dataLeft    <= sectorMode ? sectorTotal : byteCount;
      secIdx      <= '0;
      sectorModeQ <= sectorMode;
    end else begin
      if (ctl.selAddr) begin
        addrQ    <= addrQ >> 8;
        addrLeft <= addrLeft - 1'b1;
      end
      if (dataStep) begin
        dataLeft <= dataLeft - 1'b1;
        secIdx   <= (secIdx == IDX_W'(SECT_TOTAL - 1)) ? '0 : secIdx + 1'b1;
      end
    end
  end

  assign addrLast  = (addrLeft == ACNT_W'(1));
  assign dataLast  = (dataLeft == BCNT_W'(1));
  assign spareByte = ctl.selData && sectorModeQ && (secIdx >= IDX_W'(SECT_DATA));

  always_comb begin
    if (ctl.selPtr)       busOut = ptrQ;
    else if (ctl.selCmd1) busOut = cmd1Q;
    else if (ctl.selCmd2) busOut = cmd2Q;
    else if (ctl.selAddr) busOut = addrQ[7:0];
    else if (ctl.wrStep)  busOut = fifoWrData;
    else                  busOut = 8'h00;
  end

  AST_DATA_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    dataStep |-> (dataLeft != '0)); // R5
  AST_ADDR_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selAddr |-> (addrLeft != '0)); // R2
  AST_ONE_PIN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.selPtr | ctl.selCmd1 | ctl.selCmd2, ctl.selAddr, ctl.wrStep, ctl.rdStep})); // R2

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int ADDR_MAX   = 5,
  parameter int BCNT_W     = 16,
  parameter int SCNT_W     = 3,
  parameter int COL_W      = 12,
  parameter int PAGE_BYTES = 512,
  parameter int SECT_DATA  = 512,
  parameter int SECT_SPARE = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [7:0]            cmd1Code,
  input  logic [7:0]            cmd2Code,
  input  logic                  enPtr,
  input  logic [COL_W-1:0]      ptrColumn,
  input  logic                  enCmd1,
  input  logic                  enAddr,
  input  logic                  enCmd2,
  input  logic                  dirWrite,
  input  logic                  sectorMode,
  input  logic [$clog2(ADDR_MAX+1)-1:0] addrCycles,
  input  logic [8*ADDR_MAX-1:0] addrBytes,
  input  logic [BCNT_W-1:0]     byteCount,
  input  logic [SCNT_W-1:0]     sectorCount,
  input  logic                  endClear,
  input  logic                  readyIn,
  output logic                  pinCmdLatch,
  output logic                  pinAddrLatch,
  output logic                  pinWrStrobe,
  output logic                  pinRdStrobe,
  output logic [7:0]            pinDataOut,
  input  logic [7:0]            pinDataIn,
  input  logic                  fifoWrValid,
  input  logic [7:0]            fifoWrData,
  output logic                  fifoWrPop,
  input  logic                  fifoRdReady,
  output logic                  fifoRdPush,
  output logic [7:0]            fifoRdData,
  output logic                  spareByte,
  output logic                  busy,
  output logic                  xferEnd
);

  seq_cfg_t cfgLive;
  seq_ctl_t ctl;
  logic     addrLast, dataLast;

  always_comb begin
    cfgLive.enPtr    = enPtr;
    cfgLive.enCmd1   = enCmd1;
    cfgLive.enAddr   = enAddr && (addrCycles != '0);
    cfgLive.enCmd2   = enCmd2;
    cfgLive.dirWrite = dirWrite;
    cfgLive.noData   = sectorMode ? (sectorCount == '0) : (byteCount == '0);
  end

  nand_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgIn(cfgLive),
    .readyIn(readyIn), .fifoWrValid(fifoWrValid), .fifoRdReady(fifoRdReady),
    .addrLast(addrLast), .dataLast(dataLast), .endClear(endClear),
    .ctl(ctl), .busy(busy), .xferEnd(xferEnd)
  );

  nand_seq_dp #(
    .ADDR_MAX(ADDR_MAX), .BCNT_W(BCNT_W), .SCNT_W(SCNT_W), .COL_W(COL_W),
    .PAGE_BYTES(PAGE_BYTES), .SECT_DATA(SECT_DATA), .SECT_SPARE(SECT_SPARE)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmd1Code(cmd1Code), .cmd2Code(cmd2Code),
    .ptrColumn(ptrColumn), .addrBytes(addrBytes), .addrCycles(addrCycles),
    .byteCount(byteCount), .sectorCount(sectorCount), .sectorMode(sectorMode),
    .fifoWrData(fifoWrData), .busOut(pinDataOut), .addrLast(addrLast),
    .dataLast(dataLast), .spareByte(spareByte)
  );

  assign pinCmdLatch  = ctl.selPtr | ctl.selCmd1 | ctl.selCmd2;
  assign pinAddrLatch = ctl.selAddr;
  assign pinWrStrobe  = ctl.wrStep;
  assign pinRdStrobe  = ctl.rdStep;
  assign fifoWrPop    = ctl.wrStep;
  assign fifoRdPush   = ctl.rdStep;
  assign fifoRdData   = pinDataIn;

endmodule

// File: tb/tb_nand_phase_seq.sv
module tb_nand_phase_seq;

  localparam int MAXEV = 2400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd1Code = '0, cmd2Code = '0;
  logic        enPtr = 0, enCmd1 = 0, enAddr = 0, enCmd2 = 0, dirWrite = 0, sectorMode = 0;
  logic [11:0] ptrColumn = '0;
  logic [2:0]  addrCycles = '0;
  logic [39:0] addrBytes = '0;
  logic [15:0] byteCount = '0;
  logic [2:0]  sectorCount = '0;
  logic        endClear = 0, readyIn = 1;
  logic        pinCmdLatch, pinAddrLatch, pinWrStrobe, pinRdStrobe;
  logic [7:0]  pinDataOut, pinDataIn, fifoWrData, fifoRdData;
  logic        fifoWrValid, fifoWrPop, fifoRdReady, fifoRdPush;
  logic        spareByte, busy, xferEnd;

  logic        stallOn = 0, toggle = 0, cntClr = 0;
  logic [7:0]  wrSeed = '0, rdSeed = '0;
  logic [15:0] wrCnt = '0, rdCnt = '0;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  int nExp, nEv, firstCyc, capCycles;
  int         expKind [MAXEV];
  logic [7:0] expByte [MAXEV];
  int         capKind [MAXEV];
  logic [7:0] capByte [MAXEV];
  logic       capSpare[MAXEV];

  always #10 clk = ~clk;  // 50 MHz

  assign fifoWrData  = wrSeed + wrCnt[7:0];
  assign pinDataIn   = rdSeed ^ rdCnt[7:0];
  assign fifoWrValid = stallOn ? toggle : 1'b1;
  assign fifoRdReady = stallOn ? toggle : 1'b1;

  always @(posedge clk) begin
    toggle <= ~toggle;
    if (cntClr) begin
      wrCnt <= '0;
      rdCnt <= '0;
    end else begin
      if (fifoWrPop)  wrCnt <= wrCnt + 1'b1;
      if (fifoRdPush) rdCnt <= rdCnt + 1'b1;
    end
  end

  nand_phase_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .cmd1Code(cmd1Code), .cmd2Code(cmd2Code),
    .enPtr(enPtr), .ptrColumn(ptrColumn), .enCmd1(enCmd1), .enAddr(enAddr),
    .enCmd2(enCmd2), .dirWrite(dirWrite), .sectorMode(sectorMode),
    .addrCycles(addrCycles), .addrBytes(addrBytes), .byteCount(byteCount),
    .sectorCount(sectorCount), .endClear(endClear), .readyIn(readyIn),
    .pinCmdLatch(pinCmdLatch), .pinAddrLatch(pinAddrLatch), .pinWrStrobe(pinWrStrobe),
    .pinRdStrobe(pinRdStrobe), .pinDataOut(pinDataOut), .pinDataIn(pinDataIn),
    .fifoWrValid(fifoWrValid), .fifoWrData(fifoWrData), .fifoWrPop(fifoWrPop),
    .fifoRdReady(fifoRdReady), .fifoRdPush(fifoRdPush), .fifoRdData(fifoRdData),
    .spareByte(spareByte), .busy(busy), .xferEnd(xferEnd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic addExp(input int k, input logic [7:0] b);
    expKind[nExp] = k;
    expByte[nExp] = b;
    nExp++;
  endtask

  task automatic prepare();
    @(negedge clk);
    enPtr = 0; enCmd1 = 0; enAddr = 0; enCmd2 = 0; dirWrite = 0; sectorMode = 0;
    addrCycles = 0; byteCount = 0; sectorCount = 0; stallOn = 0; readyIn = 1;
    endClear = 1; cntClr = 1;
    @(negedge clk);
    endClear = 0; cntClr = 0;
    nExp = 0;
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // samples from the negedge right after the launch edge; kinds: 1 cmd, 2 addr, 3 wr, 4 rd
  task automatic capture(input int limit, input int glitchAt, input string req);
    bit done = 0;
    int cyc = 0;
    nEv = 0; firstCyc = -1;
    while (!done && cyc < limit) begin
      start = (cyc == glitchAt);
      if (pinCmdLatch || pinAddrLatch || pinWrStrobe || pinRdStrobe) begin
        if (firstCyc < 0) firstCyc = cyc;
        capKind[nEv]  = pinCmdLatch ? 1 : pinAddrLatch ? 2 : pinWrStrobe ? 3 : 4;
        capByte[nEv]  = pinRdStrobe ? fifoRdData : pinDataOut;
        capSpare[nEv] = spareByte;
        if (nEv < MAXEV - 1) nEv++;
      end
      if (pinWrStrobe && !fifoWrValid) chk(0, "R7 write strobe without fifoWrValid", 1, 0);
      if (pinRdStrobe && !fifoRdReady) chk(0, "R7 read strobe without fifoRdReady", 1, 0);
      if (pinRdStrobe && !fifoRdPush) chk(0, "R12 read strobe without push", 0, 1);
      if (xferEnd) done = 1;
      else begin
        @(negedge clk);
        cyc++;
      end
    end
    start = 0;
    capCycles = cyc;
    chk(done, {req, " transaction ended"}, done, 1);
  endtask

  task automatic compareRun(input string req);
    int mis = -1;
    chk(nEv == nExp, {req, " strobe count"}, nEv, nExp);
    for (int i = 0; i < nExp && i < nEv; i++)
      if (mis < 0 && (capKind[i] != expKind[i] || capByte[i] != expByte[i])) mis = i;
    if (mis >= 0)
      chk(0, {req, " strobe sequence (kind*256+byte)"},
          capKind[mis]*256 + capByte[mis], expKind[mis]*256 + expByte[mis]);
    else chk(1, req, 0, 0);
  endtask

  task automatic tReset();
    chk(!busy && !xferEnd, "R1 idle flags after reset", {busy, xferEnd}, 0);
    chk(!(pinCmdLatch | pinAddrLatch | pinWrStrobe | pinRdStrobe | fifoWrPop | fifoRdPush),
        "R1 strobes low after reset", 1, 0);
  endtask

  task automatic tLargeRead();
    prepare();
    enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = 0;
    cmd1Code = 8'h00; cmd2Code = 8'h30; addrCycles = 5; addrBytes = 40'h14_13_12_11_10;
    byteCount = 6; rdSeed = 8'hA5;
    addExp(1, 8'h00);
    for (int i = 0; i < 5; i++) addExp(2, 8'h10 + 8'(i));
    addExp(1, 8'h30);
    for (int i = 0; i < 6; i++) addExp(4, 8'hA5 ^ 8'(i));
    kick();
    capture(200, -1, "R3");
    chk(firstCyc == 0, "R2 first strobe in cycle after start", firstCyc, 0);
    compareRun("R3 R12 large page read");
  endtask

  task automatic tProgram();
    prepare();
    enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = 1;
    cmd1Code = 8'h80; cmd2Code = 8'h10; addrCycles = 3; addrBytes = 40'h00_00_33_22_11;
    byteCount = 5; wrSeed = 8'h40;
    addExp(1, 8'h80); addExp(2, 8'h11); addExp(2, 8'h22); addExp(2, 8'h33);
    for (int i = 0; i < 5; i++) addExp(3, 8'h40 + 8'(i));
    addExp(1, 8'h10);
    kick();
    capture(200, -1, "R2");
    compareRun("R2 program order");
  endtask

  task automatic tPointer(input logic [11:0] col, input logic [7:0] code);
    prepare();
    enPtr = 1; ptrColumn = col; enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = 1;
    cmd1Code = 8'h80; cmd2Code = 8'h10; addrCycles = 2; addrBytes = 40'h00_00_00_B2_B1;
    byteCount = 2; wrSeed = 8'h07;
    addExp(1, code); addExp(1, 8'h80); addExp(2, 8'hB1); addExp(2, 8'hB2);
    addExp(3, 8'h07); addExp(3, 8'h08); addExp(1, 8'h10);
    kick();
    capture(200, -1, "R10");
    compareRun($sformatf("R10 pointer code for column %0d", col));
  endtask

  task automatic tErase();
    prepare();
    enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = 1;
    cmd1Code = 8'h60; cmd2Code = 8'hD0; addrCycles = 3; addrBytes = 40'h00_00_C3_C2_C1;
    byteCount = 0;
    addExp(1, 8'h60); addExp(2, 8'hC1); addExp(2, 8'hC2); addExp(2, 8'hC3); addExp(1, 8'hD0);
    kick();
    capture(200, -1, "R4");
    compareRun("R4 erase without data");
  endtask

  task automatic tStatus();
    prepare();
    enCmd1 = 1; enAddr = 1; addrCycles = 0; enCmd2 = 0; dirWrite = 0;
    cmd1Code = 8'h70; byteCount = 1; rdSeed = 8'hE0;
    addExp(1, 8'h70); addExp(4, 8'hE0);
    kick();
    capture(200, -1, "R5");
    compareRun("R4 R5 status read one byte, zero address count skipped");
  endtask

  task automatic tIdRead();
    prepare();
    enCmd1 = 1; enAddr = 1; addrCycles = 1; addrBytes = '0; dirWrite = 0;
    cmd1Code = 8'h90; byteCount = 8; rdSeed = 8'h2C;
    addExp(1, 8'h90); addExp(2, 8'h00);
    for (int i = 0; i < 8; i++) addExp(4, 8'h2C ^ 8'(i));
    kick();
    capture(200, -1, "R5");
    compareRun("R5 ID read eight bytes");
  endtask

  task automatic tZeroRead();
    prepare();
    enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = 0;
    cmd1Code = 8'h00; cmd2Code = 8'h30; addrCycles = 1; addrBytes = 40'h5A;
    byteCount = 0;
    addExp(1, 8'h00); addExp(2, 8'h5A); addExp(1, 8'h30);
    kick();
    capture(200, -1, "R5");
    compareRun("R5 zero byte count skips data");
  endtask

  task automatic tSector(input bit wr, input int secs);
    int bad = 0;
    int di = 0;
    prepare();
    enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = wr; sectorMode = 1;
    sectorCount = 3'(secs); byteCount = 7;
    cmd1Code = wr ? 8'h80 : 8'h00; cmd2Code = wr ? 8'h10 : 8'h30;
    addrCycles = 5; addrBytes = 40'h04_03_02_01_00; wrSeed = 8'h11; rdSeed = 8'h3C;
    addExp(1, cmd1Code);
    for (int i = 0; i < 5; i++) addExp(2, 8'(i));
    if (!wr) addExp(1, 8'h30);
    for (int i = 0; i < secs * 528; i++)
      addExp(wr ? 3 : 4, wr ? (8'h11 + 8'(i)) : (8'h3C ^ 8'(i)));
    if (wr) addExp(1, 8'h10);
    kick();
    capture(6000, -1, "R6");
    compareRun($sformatf("R6 sector mode %0d sectors", secs));
    for (int i = 0; i < nEv; i++)
      if (capKind[i] >= 3) begin
        if (capSpare[i] != ((di % 528) >= 512)) bad++;
        di++;
      end
    chk(bad == 0, "R6 spare flag positions", bad, 0);
  endtask

  task automatic tStall(input bit wr);
    prepare();
    stallOn = 1;
    enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = wr;
    cmd1Code = wr ? 8'h80 : 8'h00; cmd2Code = wr ? 8'h10 : 8'h30;
    addrCycles = 1; addrBytes = 40'h77; byteCount = 6; wrSeed = 8'h90; rdSeed = 8'h0F;
    addExp(1, cmd1Code); addExp(2, 8'h77);
    if (!wr) addExp(1, 8'h30);
    for (int i = 0; i < 6; i++) addExp(wr ? 3 : 4, wr ? 8'h90 + 8'(i) : 8'h0F ^ 8'(i));
    if (wr) addExp(1, 8'h10);
    kick();
    capture(300, -1, "R7");
    compareRun("R7 stalled FIFO keeps order");
    chk(capCycles >= nExp + 5, "R7 stall stretches data phase", capCycles, nExp + 5);
  endtask

  task automatic tReadyAndSticky();
    prepare();
    readyIn = 0;
    enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = 1;
    cmd1Code = 8'h80; cmd2Code = 8'h10; addrCycles = 2; addrBytes = 40'h0201; byteCount = 3;
    kick();
    repeat (20) @(negedge clk);
    chk(!xferEnd && busy, "R8 held in wait while not ready", xferEnd, 0);
    readyIn = 1;
    chk(!xferEnd, "R8 no end before ready sampled", xferEnd, 0);
    @(negedge clk);
    chk(xferEnd && !busy, "R8 end one edge after ready", xferEnd, 1);
    repeat (5) @(negedge clk);
    chk(xferEnd, "R9 end flag sticky", xferEnd, 1);
    endClear = 1;
    @(negedge clk);
    endClear = 0;
    chk(!xferEnd, "R9 end flag cleared", xferEnd, 0);
  endtask

  task automatic tBusyStart();
    prepare();
    enCmd1 = 1; enAddr = 1; enCmd2 = 1; dirWrite = 1;
    cmd1Code = 8'h80; cmd2Code = 8'h10; addrCycles = 2; addrBytes = 40'h0D0C;
    byteCount = 8; wrSeed = 8'h20;
    addExp(1, 8'h80); addExp(2, 8'h0C); addExp(2, 8'h0D);
    for (int i = 0; i < 8; i++) addExp(3, 8'h20 + 8'(i));
    addExp(1, 8'h10);
    kick();
    cmd1Code = 8'hEE; cmd2Code = 8'hEF; byteCount = 2;
    capture(200, 3, "R11");
    compareRun("R11 start while busy ignored");
    repeat (3) @(negedge clk);
    chk(!busy && xferEnd, "R11 no relaunch after busy start", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tLargeRead();
    tProgram();
    tPointer(12'd600, 8'h50);
    tPointer(12'd512, 8'h50);
    tPointer(12'd100, 8'h00);
    tPointer(12'd300, 8'h01);
    tPointer(12'd256, 8'h01);
    tErase();
    tStatus();
    tIdRead();
    tZeroRead();
    tSector(1'b0, 4);
    tSector(1'b1, 1);
    tStall(1'b1);
    tStall(1'b0);
    tReadyAndSticky();
    tBusyStart();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule